// File: doc/BRIEF.md
# General-Purpose Flag Interrupt Controller

This block manages sixteen general-purpose pins and raises two separate interrupt lines, A and B. A simple synchronous register bus carries all software access. Each register is written in one cycle, and its read data is available combinationally in the cycle its address is presented. The flag bits and both interrupt masks are changed through paired write-1-to-set and write-1-to-clear addresses. As a result, software never has to read, modify and write back a whole register to change one bit.

Each pin is configured through three per-pin bits:
- **Direction:** `1` drives the pin from its flag bit; `0` makes it an input.
- **Sensing:** level or edge.
- **Polarity:** active-high or active-low for level sensing; rising or falling for edge sensing.

Input pins pass through a two-stage synchronizer before any sensing. A detected edge is held in the flag bit until software writes 1 to that bit at the flag clear address. Each interrupt output is the registered OR, over all pins, of the flag bit ANDed with that interrupt's own mask bit.

Top module: `gpio_flag_irq`

## Requirements
- R1: After reset, the following are all zero: flags, both masks, direction, polarity and sensing bits. Every address reads 0, `pin_oe` is 0, and `irq_a` and `irq_b` are low.
- R2: Mask A is set at address 5 and cleared at address 6. Mask B is set at address 7 and cleared at address 8. A 1 in the write data sets or clears that bit, and a 0 leaves it unchanged. Reading either address of a pair returns the current mask.
- R3: A write to a mask A address never changes mask B, and a write to a mask B address never changes mask A.
- R4: Writing to address 0 sets flag bits and writing to address 1 clears them, with write-1 semantics. Reading either address returns the flags. For an output pin (direction bit 1), `pin_out` carries the flag bit.
- R5: For an input pin in level mode (sensing bit 0), the flag follows the synchronized pin. With polarity bit 0 the flag equals the pin; with polarity bit 1 it equals the inverted pin.
- R6: For an input pin in edge mode (sensing bit 1), polarity bit 0 selects a rising edge and polarity bit 1 a falling edge. A detected edge sets the flag, and the flag stays set until a 1 is written to that bit at address 1.
- R7: When an edge is detected in the same cycle that a clear write hits that bit, the flag stays set.
- R8: `irq_a` equals the OR of (flag AND mask A) as it stood one cycle earlier. `irq_b` is formed the same way from mask B.
- R9: A pin change sampled at clock edge k reaches the flag at edge k+2 and not before, after the two-stage synchronizer.
- R10: Address 2 holds direction and drives `pin_oe`. Address 3 holds polarity and address 4 holds sensing mode. All three read back as written, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Pin input levels, asynchronous |
| pin_out | output | 16 | Pin output levels, equal to the flag bits |
| pin_oe | output | 16 | Pin output enables, from the direction register |
| irq_a | output | 1 | Interrupt A |
| irq_b | output | 1 | Interrupt B |

## Verification
The assertions take `bus_addr`, `bus_wr` and `bus_wdata` to be steady for a whole cycle. They also take the synchronized pin, the configuration and the strobes to be sampled at the same edge as the flag they govern. The bench drives every bus and pin change half a cycle away from the rising edge. It holds each pin level for at least four cycles so that every edge passes the synchronizer intact. For the same-cycle case it times the clear write to land in exactly the cycle in which the synchronized edge is seen.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned NUM_IRQ = 2;

    typedef enum logic [ADDR_W-1:0] {
        AD_FLAG_SET = 4'h0,
        AD_FLAG_CLR = 4'h1,
        AD_DIR      = 4'h2,
        AD_POL      = 4'h3,
        AD_SENSE    = 4'h4,
        AD_MSKA_SET = 4'h5,
        AD_MSKA_CLR = 4'h6,
        AD_MSKB_SET = 4'h7,
        AD_MSKB_CLR = 4'h8
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

    // Warm-up counter so the two-cycle look-back never reaches before reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)               warm_q <= '0;
        else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end

    // R9
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_w1sc_reg.sv
module gpio_w1sc_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val
);
    typedef struct packed {
        logic [W-1:0] bits;
    } w1sc_t;

    w1sc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stb) st_d.bits = st_d.bits | wdata;
        if (clr_stb) st_d.bits = st_d.bits & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.bits;

    // R2
    set_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !clr_stb) |=> ((val & $past(wdata)) == $past(wdata)));
    // R2
    clr_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb) |=> ((val & $past(wdata)) == '0));
    // R2
    zero_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> ((val & ~$past(wdata)) == ($past(val) & ~$past(wdata))));
    // R3
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(val));
endmodule

// File: rtl/gpio_flag_unit.sv
module gpio_flag_unit #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] sense_edge,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flag
);
    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] prev;
    } fu_t;

    fu_t st_d, st_q;

    logic [W-1:0] set_vec, clr_vec, lvl_act, edge_hit, sw_val, lvl_sel, edg_sel;

    always_comb begin
        set_vec  = set_stb ? wdata : '0;
        clr_vec  = clr_stb ? wdata : '0;
        lvl_act  = pin_s ^ pol;
        edge_hit = (pol & st_q.prev & ~pin_s) | (~pol & pin_s & ~st_q.prev);
        lvl_sel  = ~dir & ~sense_edge;
        edg_sel  = ~dir & sense_edge;
        sw_val   = (st_q.flag | set_vec) & ~clr_vec;

        st_d.flag = (lvl_sel & lvl_act) | (~lvl_sel & sw_val) | (edg_sel & edge_hit);
        st_d.prev = pin_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((flag ^ $past(pin_s ^ pol)) & $past(lvl_sel)) == '0));
    // R6
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~flag & $past(flag & edg_sel & ~clr_vec)) == '0));
    // R7
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(edg_sel & edge_hit & clr_vec)) |=>
            ((flag & $past(edg_sel & edge_hit)) == $past(edg_sel & edge_hit)));
    // R4
    out_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> ((($past(flag) ^ flag) & $past(dir)) == '0));
endmodule

// File: rtl/gpio_flag_irq.sv
module gpio_flag_irq
    import gpio_flag_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_a,
    output logic              irq_b
);
    typedef struct packed {
        logic [NPINS-1:0]   dir;
        logic [NPINS-1:0]   pol;
        logic [NPINS-1:0]   sense_edge;
        logic [NUM_IRQ-1:0] irq;
    } top_t;

    top_t st_d, st_q;

    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] flag;
    logic [NUM_IRQ-1:0][NPINS-1:0] mask;
    logic flag_set_stb, flag_clr_stb;

    assign flag_set_stb = bus_wr && (bus_addr == AD_FLAG_SET);
    assign flag_clr_stb = bus_wr && (bus_addr == AD_FLAG_CLR);

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    gpio_flag_unit #(.W(NPINS)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_s      (pin_s),
        .dir        (st_q.dir),
        .pol        (st_q.pol),
        .sense_edge (st_q.sense_edge),
        .set_stb    (flag_set_stb),
        .clr_stb    (flag_clr_stb),
        .wdata      (bus_wdata),
        .flag       (flag)
    );

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_mask
        localparam logic [ADDR_W-1:0] SET_AD = ADDR_W'(int'(AD_MSKA_SET) + 2 * g);
        localparam logic [ADDR_W-1:0] CLR_AD = ADDR_W'(int'(AD_MSKA_CLR) + 2 * g);
        logic set_stb, clr_stb;
        assign set_stb = bus_wr && (bus_addr == SET_AD);
        assign clr_stb = bus_wr && (bus_addr == CLR_AD);
        gpio_w1sc_reg #(.W(NPINS)) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_stb),
            .clr_stb (clr_stb),
            .wdata   (bus_wdata),
            .val     (mask[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (bus_addr)
                AD_DIR:   st_d.dir        = bus_wdata;
                AD_POL:   st_d.pol        = bus_wdata;
                AD_SENSE: st_d.sense_edge = bus_wdata;
                default:  ;
            endcase
        end
        for (int i = 0; i < NUM_IRQ; i++) begin
            st_d.irq[i] = |(flag & mask[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            AD_FLAG_SET, AD_FLAG_CLR: bus_rdata = flag;
            AD_DIR:                   bus_rdata = st_q.dir;
            AD_POL:                   bus_rdata = st_q.pol;
            AD_SENSE:                 bus_rdata = st_q.sense_edge;
            AD_MSKA_SET, AD_MSKA_CLR: bus_rdata = mask[0];
            AD_MSKB_SET, AD_MSKB_CLR: bus_rdata = mask[1];
            default:                  bus_rdata = '0;
        endcase
    end

    assign pin_out = flag;
    assign pin_oe  = st_q.dir;
    assign irq_a   = st_q.irq[0];
    assign irq_b   = st_q.irq[1];

    // R3
    a_write_b_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == AD_MSKA_SET || bus_addr == AD_MSKA_CLR)) |=> $stable(mask[1]));
    // R3
    b_write_a_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == AD_MSKB_SET || bus_addr == AD_MSKB_CLR)) |=> $stable(mask[0]));
    // R8
    irq_a_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_a == $past(|(flag & mask[0]))));
    // R8
    irq_b_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_b == $past(|(flag & mask[1]))));
    // R10
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AD_DIR) |=> (pin_oe == $past(bus_wdata)));
endmodule

// File: tb/sim_gpio_flag_irq.sv
module sim_gpio_flag_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq_a, irq_b;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_flag_irq u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 reset read", {16'h0, v}, 32'h0);
        end
        chk("R1 reset irq_a", {31'h0, irq_a}, 32'h0);
        chk("R1 reset irq_b", {31'h0, irq_b}, 32'h0);
        chk("R1 reset pin_oe", {16'h0, pin_oe}, 32'h0);
    endtask

    task automatic t_masks;
        logic [15:0] v;
        wr(4'h5, 16'h00F0);
        rd(4'h5, v); chk("R2 mask A via set addr", {16'h0, v}, 32'h00F0);
        rd(4'h6, v); chk("R2 mask A via clr addr", {16'h0, v}, 32'h00F0);
        wr(4'h5, 16'h0F00);
        rd(4'h5, v); chk("R2 zero bits unchanged on set", {16'h0, v}, 32'h0FF0);
        wr(4'h6, 16'h0030);
        rd(4'h6, v); chk("R2 clear ones only", {16'h0, v}, 32'h0FC0);
        rd(4'h7, v); chk("R3 mask B untouched by A", {16'h0, v}, 32'h0);
        wr(4'h7, 16'h8001);
        rd(4'h5, v); chk("R3 mask A untouched by B set", {16'h0, v}, 32'h0FC0);
        wr(4'h8, 16'h0001);
        rd(4'h7, v); chk("R2 mask B clear", {16'h0, v}, 32'h8000);
        rd(4'h6, v); chk("R3 mask A untouched by B clr", {16'h0, v}, 32'h0FC0);
        wr(4'h6, 16'hFFFF);
        wr(4'h8, 16'hFFFF);
        rd(4'h5, v); chk("R2 mask A all cleared", {16'h0, v}, 32'h0);
        rd(4'h8, v); chk("R2 mask B all cleared", {16'h0, v}, 32'h0);
    endtask

    task automatic t_outflag;
        logic [15:0] v;
        wr(4'h2, 16'h00FF);
        rd(4'h2, v); chk("R10 dir readback", {16'h0, v}, 32'h00FF);
        chk("R10 pin_oe", {16'h0, pin_oe}, 32'h00FF);
        wr(4'h0, 16'h0003);
        rd(4'h0, v); chk("R4 flag set", {16'h0, v}, 32'h0003);
        chk("R4 pin_out", {16'h0, pin_out & 16'h00FF}, 32'h0003);
        wr(4'h1, 16'h0001);
        rd(4'h1, v); chk("R4 flag clear", {16'h0, v}, 32'h0002);
        chk("R4 pin_out after clear", {16'h0, pin_out & 16'h00FF}, 32'h0002);
        tick(3);
        rd(4'h0, v); chk("R4 output flag held", {16'h0, v}, 32'h0002);
        rd(4'hF, v); chk("R10 unused address", {16'h0, v}, 32'h0);
        rd(4'h9, v); chk("R10 unused address 9", {16'h0, v}, 32'h0);
    endtask

    task automatic t_irq;
        wr(4'h5, 16'h0002);
        chk("R8 irq_a one cycle later, not yet", {31'h0, irq_a}, 32'h0);
        tick();
        chk("R8 irq_a asserted", {31'h0, irq_a}, 32'h1);
        chk("R3 irq_b stays low", {31'h0, irq_b}, 32'h0);
        wr(4'h7, 16'h0002);
        tick();
        chk("R8 irq_b asserted", {31'h0, irq_b}, 32'h1);
        wr(4'h6, 16'h0002);
        tick();
        chk("R3 irq_a off, mask A cleared", {31'h0, irq_a}, 32'h0);
        chk("R3 irq_b still on", {31'h0, irq_b}, 32'h1);
        wr(4'h1, 16'h0002);
        tick();
        chk("R8 irq_b off after flag clear", {31'h0, irq_b}, 32'h0);
        wr(4'h8, 16'hFFFF);
    endtask

    task automatic t_level;
        logic [15:0] v;
        pin_in[8] = 1'b1;
        tick();
        rd(4'h0, v); chk("R9 no flag after one edge", {31'h0, v[8]}, 32'h0);
        tick();
        rd(4'h0, v); chk("R9 no flag after two edges", {31'h0, v[8]}, 32'h0);
        tick();
        rd(4'h0, v); chk("R5 R9 level high seen", {31'h0, v[8]}, 32'h1);
        wr(4'h3, 16'h0100);
        rd(4'h3, v); chk("R10 pol readback", {16'h0, v}, 32'h0100);
        tick();
        rd(4'h0, v); chk("R5 active-low, pin high", {31'h0, v[8]}, 32'h0);
        pin_in[8] = 1'b0;
        tick(3);
        rd(4'h0, v); chk("R5 active-low, pin low", {31'h0, v[8]}, 32'h1);
        wr(4'h5, 16'h0100);
        tick();
        chk("R8 level flag to irq_a", {31'h0, irq_a}, 32'h1);
        wr(4'h6, 16'hFFFF);
    endtask

    task automatic t_edge;
        logic [15:0] v;
        wr(4'h4, 16'h0200);
        rd(4'h4, v); chk("R10 sense readback", {16'h0, v}, 32'h0200);
        pin_in[9] = 1'b1;
        tick(4);
        rd(4'h0, v); chk("R6 rising edge latched", {31'h0, v[9]}, 32'h1);
        pin_in[9] = 1'b0;
        tick(4);
        rd(4'h0, v); chk("R6 held after pin falls", {31'h0, v[9]}, 32'h1);
        wr(4'h1, 16'h0200);
        rd(4'h0, v); chk("R6 cleared by write", {31'h0, v[9]}, 32'h0);
        wr(4'h3, 16'h0300);
        pin_in[9] = 1'b1;
        tick(4);
        rd(4'h0, v); chk("R6 falling mode ignores rise", {31'h0, v[9]}, 32'h0);
        pin_in[9] = 1'b0;
        tick(4);
        rd(4'h0, v); chk("R6 falling edge latched", {31'h0, v[9]}, 32'h1);
        wr(4'h1, 16'h0200);
        rd(4'h0, v); chk("R6 falling flag cleared", {31'h0, v[9]}, 32'h0);
    endtask

    task automatic t_race;
        logic [15:0] v;
        pin_in[9] = 1'b1;
        tick(4);
        pin_in[9] = 1'b0;
        tick(2);
        wr(4'h1, 16'h0200);
        rd(4'h0, v); chk("R7 edge beats same-cycle clear", {31'h0, v[9]}, 32'h1);
        wr(4'h1, 16'h0200);
        rd(4'h0, v); chk("R7 later clear works", {31'h0, v[9]}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_outflag();
        t_irq();
        t_level();
        t_edge();
        t_race();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule